// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream, made of a bit clock, a frame clock and one data line, into parallel 24-bit left and right samples with a single-cycle valid strobe. Four framing variants are decoded: I2S, left-justified, right-justified (16, 20 or 24-bit words) and a pulsed DSP framing in which the frame clock only marks the start of each word. Samples are two's complement, sent MSB first, and the left field of a frame always comes before the right one.

The serial lines are sampled by a faster system clock. Both bit-clock edges are detected inside that clock domain, so the receiver can capture on either edge, and it is not disturbed by a bit clock that stops between bits. A field ends when the next field starts. Its word is then left-aligned, or sign-extended for right-justified input, into the 24-bit output. When the right field of a frame ends, both channel outputs update together.

Top module: `srx_receiver`

## Requirements
- R1: While `rst` is high and in the cycle after it, `word_valid` is 0 and both sample outputs are 0.
- R2: With `fmt_sel` = 00 (I2S), a low frame clock marks the left field and a high one the right. The first rising bit-clock edge after a frame-clock change carries no data, and the MSB is taken at the second rising edge.
- R3: With `fmt_sel` = 01 (left-justified), a high frame clock marks the left field. The MSB is taken at the first rising bit-clock edge after the frame-clock change.
- R4: With `fmt_sel` = 10 (right-justified), a high frame clock marks the left field, each half frame is 32 bit clocks long, and the word fills its last W rising edges. W is 24 for `rj_len_sel` = 00 or 11, 20 for 01, and 16 for 10.
- R5: A 20-bit or 16-bit right-justified word is sign-extended to 24 bits.
- R6: With `fmt_sel` = 11 (DSP), data is taken on falling bit-clock edges. A field starts at the first falling edge where the frame clock is low after being high, and that edge carries the MSB. The first such field after reset is left, and fields then alternate left and right.
- R7: In I2S, left-justified and DSP modes, only the first 24 bits of a field are kept. A shorter word is left-aligned, with zeros in the unused low bits.
- R8: `word_valid` is a one-cycle pulse raised when a right field closes, that is, at the first capture of the next field. Both sample outputs change only in that cycle.
- R9: Stopping the bit clock for any number of system cycles between bits does not alter the received words.
- R10: Any change of `fmt_sel` or `rj_len_sel` discards the open field. It also restarts DSP channel tracking, so the next DSP field is taken as left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each bit-clock level must last at least one cycle |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock, may pause |
| frame_clk | input | 1 | Frame clock (channel level or DSP start pulse) |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| rj_len_sel | input | 2 | Right-justified word length: 00 24, 01 20, 10 16, 11 24 |
| left_word | output | 24 | Last completed left sample |
| right_word | output | 24 | Last completed right sample |
| word_valid | output | 1 | One-cycle pulse when a left/right pair is updated |

## Verification
Closing one field and opening the next happen on the same captured edge. The bit taken on that edge belongs to the new field, either as its MSB (left-justified, right-justified timing, DSP) or as a discarded lead bit (I2S), while the finished word is finalized from the register contents as they stood before the edge. Each framing is driven with lead, target and trailing frames, so that the target's right word closes on the edge that also carries the trailing frame's first bit. This checks that the two actions do not mix. Words of 16, 20, 24 and 28 bits, bit-clock pauses, and a mode change made in the middle of a DSP frame also run through the same field boundary.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int SLOT_BITS = 32;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        WL_24  = 2'b00,
        WL_20  = 2'b01,
        WL_16  = 2'b10,
        WL_RSV = 2'b11
    } wlen_e;

    // one captured serial bit together with its frame-clock level
    typedef struct packed {
        logic stb;
        logic lr;
        logic dat;
    } cap_t;

    function automatic int rj_bits(wlen_e w);
        case (w)
            WL_20:   return 20;
            WL_16:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync
    import srx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    input  logic frame_clk,
    input  logic ser_data,
    input  logic fall_edge,
    output cap_t cap
);
    logic bclk_q, bclk_qq, lr_q, sd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            bclk_qq <= 1'b0;
            lr_q    <= 1'b0;
            sd_q    <= 1'b0;
        end else begin
            bclk_q  <= bit_clk;
            bclk_qq <= bclk_q;
            lr_q    <= frame_clk;
            sd_q    <= ser_data;
        end
    end

    // frame clock and data are taken from the same sample as the new bit-clock level
    always_comb begin
        cap.stb = fall_edge ? (bclk_qq & ~bclk_q) : (bclk_q & ~bclk_qq);
        cap.lr  = lr_q;
        cap.dat = sd_q;
    end
endmodule

// File: rtl/srx_field_ctrl.sv
module srx_field_ctrl
    import srx_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int SLOT   = SLOT_BITS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  cap_t                       cap,
    input  fmt_e                       fmt,
    input  wlen_e                      wl,
    output logic                       start,
    output logic                       close,
    output logic                       close_right,
    output logic                       take,
    output logic [$clog2(DATA_W)-1:0]  tgt
);
    localparam int CNT_W = $clog2(2 * SLOT);
    localparam int TGT_W = $clog2(DATA_W);

    logic             have_prev, prev_lr, open, cur_right, dsp_left_next;
    logic [CNT_W-1:0] cnt, idx;
    fmt_e             fmt_q;
    wlen_e            wl_q;
    logic             restart, new_right, live;
    int               idx_i, wbits;

    assign restart = (fmt != fmt_q) || (wl != wl_q);

    always_comb begin
        if (fmt == FMT_DSP)
            start = cap.stb && have_prev && prev_lr && !cap.lr && !restart;
        else
            start = cap.stb && have_prev && (cap.lr != prev_lr) && !restart;

        case (fmt)
            FMT_I2S: new_right = cap.lr;
            FMT_DSP: new_right = !dsp_left_next;
            default: new_right = !cap.lr;
        endcase

        close       = start && open;
        close_right = cur_right;
        idx         = start ? '0 : cnt;
        idx_i       = int'(idx);
        live        = (start || open) && cap.stb && !restart;
        wbits       = rj_bits(wl);
        take        = 1'b0;
        tgt         = '0;
        case (fmt)
            FMT_I2S: if (idx_i >= 1 && idx_i <= DATA_W) begin
                take = live;
                tgt  = TGT_W'(DATA_W - idx_i);
            end
            FMT_RJ: if (idx_i >= SLOT - wbits && idx_i < SLOT) begin
                take = live;
                tgt  = TGT_W'(SLOT - 1 - idx_i);
            end
            default: if (idx_i < DATA_W) begin
                take = live;
                tgt  = TGT_W'(DATA_W - 1 - idx_i);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        fmt_q <= fmt;
        wl_q  <= wl;
        if (rst || restart) begin
            have_prev     <= 1'b0;
            prev_lr       <= 1'b0;
            open          <= 1'b0;
            cur_right     <= 1'b0;
            dsp_left_next <= 1'b1;
            cnt           <= '0;
        end else if (cap.stb) begin
            have_prev <= 1'b1;
            prev_lr   <= cap.lr;
            if (start) begin
                open      <= 1'b1;
                cur_right <= new_right;
                cnt       <= CNT_W'(1);
                if (fmt == FMT_DSP)
                    dsp_left_next <= ~dsp_left_next;
            end else if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/srx_word_asm.sv
module srx_word_asm
    import srx_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_stb,
    input  logic                       cap_dat,
    input  logic                       start,
    input  logic                       take,
    input  logic [$clog2(DATA_W)-1:0]  tgt,
    input  logic                       close,
    input  logic                       close_right,
    input  fmt_e                       fmt,
    input  wlen_e                      wl,
    output logic [DATA_W-1:0]          left_word,
    output logic [DATA_W-1:0]          right_word,
    output logic                       word_valid
);
    localparam int TGT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sh, sh_nxt, fin, pend_l;
    logic [TGT_W-1:0]  sign_pos;
    int                wbits;

    always_comb begin
        sh_nxt = start ? '0 : sh;
        if (take)
            sh_nxt[tgt] = cap_dat;

        wbits    = rj_bits(wl);
        sign_pos = TGT_W'(wbits - 1);
        for (int i = 0; i < DATA_W; i++)
            fin[i] = (fmt == FMT_RJ && i >= wbits) ? sh[sign_pos] : sh[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            pend_l     <= '0;
            left_word  <= '0;
            right_word <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (cap_stb)
                sh <= sh_nxt;
            if (close) begin
                if (close_right) begin
                    left_word  <= pend_l;
                    right_word <= fin;
                    word_valid <= 1'b1;
                end else begin
                    pend_l <= fin;
                end
            end
        end
    end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
    import srx_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int SLOT   = SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_clk,
    input  logic              frame_clk,
    input  logic              ser_data,
    input  logic [1:0]        fmt_sel,
    input  logic [1:0]        rj_len_sel,
    output logic [DATA_W-1:0] left_word,
    output logic [DATA_W-1:0] right_word,
    output logic              word_valid
);
    localparam int TGT_W = $clog2(DATA_W);

    fmt_e             fmt_s;
    wlen_e            wl_s;
    cap_t             cap_w;
    logic             start_w, close_w, close_r_w, take_w;
    logic [TGT_W-1:0] tgt_w;

    assign fmt_s = fmt_e'(fmt_sel);
    assign wl_s  = wlen_e'(rj_len_sel);

    srx_edge_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .bit_clk   (bit_clk),
        .frame_clk (frame_clk),
        .ser_data  (ser_data),
        .fall_edge (fmt_s == FMT_DSP),
        .cap       (cap_w)
    );

    srx_field_ctrl #(.DATA_W(DATA_W), .SLOT(SLOT)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cap         (cap_w),
        .fmt         (fmt_s),
        .wl          (wl_s),
        .start       (start_w),
        .close       (close_w),
        .close_right (close_r_w),
        .take        (take_w),
        .tgt         (tgt_w)
    );

    srx_word_asm #(.DATA_W(DATA_W)) u_asm (
        .clk         (clk),
        .rst         (rst),
        .cap_stb     (cap_w.stb),
        .cap_dat     (cap_w.dat),
        .start       (start_w),
        .take        (take_w),
        .tgt         (tgt_w),
        .close       (close_w),
        .close_right (close_r_w),
        .fmt         (fmt_s),
        .wl          (wl_s),
        .left_word   (left_word),
        .right_word  (right_word),
        .word_valid  (word_valid)
    );
endmodule

// File: rtl/srx_receiver_chk.sv
module srx_receiver_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        fmt_sel,
    input logic [1:0]        rj_len_sel,
    input logic              cap_stb,
    input logic [DATA_W-1:0] left_word,
    input logic [DATA_W-1:0] right_word,
    input logic              word_valid
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!word_valid && left_word == '0 && right_word == '0));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> ($stable(left_word) && $stable(right_word)));

    assert_valid_after_capture_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(cap_stb));

    assert_sext16_R5: assert property (@(posedge clk) disable iff (rst)
        (word_valid && $past(fmt_sel) == 2'b10 && $past(rj_len_sel) == 2'b10)
        |-> ($countones(right_word[DATA_W-1:15]) == 0 ||
             $countones(right_word[DATA_W-1:15]) == DATA_W - 15));

    assert_sext20_R5: assert property (@(posedge clk) disable iff (rst)
        (word_valid && $past(fmt_sel) == 2'b10 && $past(rj_len_sel) == 2'b01)
        |-> ($countones(right_word[DATA_W-1:19]) == 0 ||
             $countones(right_word[DATA_W-1:19]) == DATA_W - 19));
endmodule

bind srx_receiver srx_receiver_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .fmt_sel    (fmt_sel),
    .rj_len_sel (rj_len_sel),
    .cap_stb    (cap_w.stb),
    .left_word  (left_word),
    .right_word (right_word),
    .word_valid (word_valid)
);

// File: tb/test_srx_receiver.sv
module test_srx_receiver;
    localparam int H   = 4;   // system cycles per bit-clock half period
    localparam int GAP = 37;  // stall length for burst test
    localparam int NV  = 10;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [1:0]  wl;
        logic [5:0]  nb;
        logic [31:0] lw;
        logic [31:0] rw;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b00, 2'b00, 6'd24, 32'h0123456, 32'h0ABCDEF, 24'h123456, 24'hABCDEF},
        '{2'b01, 2'b00, 6'd24, 32'h07FFFFF, 32'h0800001, 24'h7FFFFF, 24'h800001},
        '{2'b01, 2'b00, 6'd16, 32'h0001234, 32'h0008001, 24'h123400, 24'h800100},
        '{2'b10, 2'b00, 6'd24, 32'h0654321, 32'h09ABCDE, 24'h654321, 24'h9ABCDE},
        '{2'b10, 2'b01, 6'd20, 32'h0080000, 32'h007FFFF, 24'hF80000, 24'h07FFFF},
        '{2'b10, 2'b10, 6'd16, 32'h0008000, 32'h0001234, 24'hFF8000, 24'h001234},
        '{2'b11, 2'b00, 6'd24, 32'h00F0F0F, 32'h0F0F0F0, 24'h0F0F0F, 24'hF0F0F0},
        '{2'b00, 2'b00, 6'd28, 32'hABCDEF1, 32'h1234567, 24'hABCDEF, 24'h123456},
        '{2'b11, 2'b00, 6'd20, 32'h00FFFFF, 32'h0012345, 24'hFFFFF0, 24'h123450},
        '{2'b01, 2'b00, 6'd28, 32'h8000000, 32'hFFFFFFF, 24'h800000, 24'hFFFFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0, frame_clk = 1'b0, ser_data = 1'b0;
    logic [1:0]  fmt_sel = 2'b00, rj_len_sel = 2'b00;
    logic [23:0] left_word, right_word;
    logic        word_valid;

    int checks = 0, errors = 0;
    int vcnt = 0, dbl = 0;
    logic [23:0] last_l = '0, last_r = '0;
    logic prev_v = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    srx_receiver i_srx_receiver (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .frame_clk(frame_clk),
        .ser_data(ser_data), .fmt_sel(fmt_sel), .rj_len_sel(rj_len_sel),
        .left_word(left_word), .right_word(right_word), .word_valid(word_valid)
    );

    always @(negedge clk) begin
        if (!rst && word_valid) begin
            vcnt++;
            last_l = left_word;
            last_r = right_word;
            if (prev_v) dbl++;
        end
        prev_v = word_valid;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            3: return "R4";
            4, 5: return "R5";
            6, 8: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        bit_clk = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_half(input logic [1:0] f, input int h, input logic [31:0] w,
                             input int nb, input int gap_slot);
        for (int j = 0; j < 32; j++) begin
            logic lv, b;
            int k;
            case (f)
                2'b00: begin lv = (h == 1); k = j - 1; end
                2'b11: begin lv = (j == 0); k = j - 1; end
                2'b10: begin lv = (h == 0); k = j - (32 - nb); end
                default: begin lv = (h == 0); k = j; end
            endcase
            b = (k >= 0 && k < nb) ? w[nb - 1 - k] : 1'b0;
            if (f == 2'b11) begin
                bit_clk = 1'b1; frame_clk = lv; ser_data = b;
                repeat (H) @(negedge clk);
                bit_clk = 1'b0;
                repeat (H) @(negedge clk);
            end else begin
                bit_clk = 1'b0; frame_clk = lv; ser_data = b;
                repeat (H) @(negedge clk);
                bit_clk = 1'b1;
                repeat (H) @(negedge clk);
            end
            if (j == gap_slot) repeat (GAP) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [1:0] f, input logic [31:0] lw, input logic [31:0] rw,
                              input int nb, input int gap_slot);
        send_half(f, 0, lw, nb, gap_slot);
        send_half(f, 1, rw, nb, gap_slot);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {8'h0, left_word}, 32'h0);
        check("R1", {8'h0, right_word}, 32'h0);
        check("R1", {31'h0, word_valid}, 32'h0);
        rst = 1'b0;

        // table of framings: lead, target and trailing frames
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            do_reset();
            fmt_sel = v.fmt; rj_len_sel = v.wl;
            repeat (2) @(negedge clk);
            c0 = vcnt;
            send_frame(v.fmt, ~v.lw, ~v.rw, int'(v.nb), -1);
            send_frame(v.fmt, v.lw, v.rw, int'(v.nb), -1);
            send_frame(v.fmt, 32'h0, 32'h0, int'(v.nb), -1);
            repeat (4) @(negedge clk);
            check(vtag(i), {8'h0, last_l}, {8'h0, v.el});
            check(vtag(i), {8'h0, last_r}, {8'h0, v.er});
            check("R8", vcnt - c0, 2);
        end

        // R9: bit clock stalls inside both fields of the target frame
        do_reset();
        fmt_sel = 2'b01; rj_len_sel = 2'b00;
        repeat (2) @(negedge clk);
        send_frame(2'b01, 32'h111111, 32'h222222, 24, -1);
        send_frame(2'b01, 32'hC3A55A, 32'h3C5AA5, 24, 6);
        send_frame(2'b01, 32'h0, 32'h0, 24, 0);
        repeat (4) @(negedge clk);
        check("R9", {8'h0, last_l}, 32'hC3A55A);
        check("R9", {8'h0, last_r}, 32'h3C5AA5);

        // R10: leave DSP mode after an odd number of pulses, then return
        do_reset();
        fmt_sel = 2'b11; rj_len_sel = 2'b00;
        repeat (2) @(negedge clk);
        send_frame(2'b11, 32'hAAAAAA, 32'h555555, 24, -1);
        send_half(2'b11, 0, 32'h777777, 24, -1);
        fmt_sel = 2'b01;
        repeat (5) @(negedge clk);
        fmt_sel = 2'b11;
        repeat (5) @(negedge clk);
        send_frame(2'b11, 32'h010203, 32'h040506, 24, -1);
        send_frame(2'b11, 32'h9E8D7C, 32'h6B5A49, 24, -1);
        send_frame(2'b11, 32'h0, 32'h0, 24, -1);
        repeat (4) @(negedge clk);
        check("R10", {8'h0, last_l}, 32'h9E8D7C);
        check("R10", {8'h0, last_r}, 32'h6B5A49);

        // R8: valid never lasted two cycles
        check("R8", dbl, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule